// File: doc/BRIEF.md
# AES Column Mixing Unit (Forward and Inverse)

This block applies the AES column mixing step to a full 128-bit cipher state. It can apply the forward transform used in encryption or the inverse transform used in decryption. The state is split into `NCOL` columns of four bytes. Each column is handled by its own copy of one shared datapath. One select input picks the direction for the whole state. The result is registered, so it appears one clock after the input.

Every constant multiplication in GF(2^8) is built from doubling steps and XOR gates only. The forward transform uses the common XOR of all four bytes, plus one doubling of each pair of neighbouring bytes. Decryption reuses that forward datapath. Before the forward stage, a small correction stage folds a fourfold-doubled XOR of the even bytes into bytes 0 and 2. It folds the matching term for the odd bytes into bytes 1 and 3. In encryption the correction terms are zero.

The unit sits in a round datapath between the row shift and the key addition. Byte substitution and round sequencing are outside this block.

Top module: `mixcol_state`

## Requirements
- R1: While `rst_n` is low, `state_out` is all zeros.
- R2: `state_out` changes only on a rising clock edge. It shows the transform of the `state_in` and `dec` values sampled at the previous edge. Between edges it holds.
- R3: With `dec`=0, each column is multiplied by the forward AES polynomial. Column c occupies `state_in[127-32c -: 32]`, and byte r of a column sits at bits `[31-8r -: 8]` of that column. Example: column db,13,53,45 maps to 8e,4d,a1,bc.
- R4: With `dec`=1, each column is multiplied by the inverse polynomial. Example: column 8e,4d,a1,bc maps back to db,13,53,45. Decrypting the result of any encryption returns the original state.
- R5: The direction is taken per cycle together with its data. `dec` may change on every cycle without corrupting any result.
- R6: Columns are independent. A change in one input column leaves the other output columns unchanged.
- R7: In both directions, the XOR of the four output bytes of a column equals the XOR of its four input bytes.
- R8: An all-zero column maps to an all-zero column in both directions.
- R9: Doubling reduces by 0x1B when the top bit is set. Example: column f2,0a,22,5c maps to 9f,dc,58,9d in encryption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec | input | 1 | 0 = forward mixing, 1 = inverse mixing |
| state_in | input | 128 | State to transform, column 0 in the top 32 bits |
| state_out | output | 128 | Registered transformed state |

## Verification
Two events can meet in the same cycle: a change of direction and the arrival of a new state. The pre-correction stage and the forward stage must both follow the new `dec` at once. The bench drives back-to-back states while flipping `dec` at random on each cycle. It checks every output against a reference model that uses general GF(2^8) multiplication, computed for the direction that was paired with that state. Round trips are also checked: an encrypted state is fed back with `dec` set, and the original state must come back.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

    // Multiply one field element by x, reducing modulo the AES polynomial.
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
    endfunction

    // Byte r of a column word; byte 0 sits in the most significant lane.
    function automatic logic [BYTE_W-1:0] col_byte(input logic [COL_W-1:0] c, input int r);
        return c[COL_W-1-BYTE_W*r -: BYTE_W];
    endfunction
endpackage

// File: rtl/mixcol_precorr.sv
// Decryption pre-correction: after it, the forward stage yields the inverse mix.
module mixcol_precorr
    import mixcol_pkg::*;
(
    input  logic             dec,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    logic [BYTE_W-1:0] even_term;
    logic [BYTE_W-1:0] odd_term;

    always_comb begin
        even_term = '0;
        odd_term  = '0;
        if (dec) begin
            even_term = gf_dbl(gf_dbl(col_byte(col_in, 0) ^ col_byte(col_in, 2)));
            odd_term  = gf_dbl(gf_dbl(col_byte(col_in, 1) ^ col_byte(col_in, 3)));
        end
    end

    for (genvar r = 0; r < COL_BYTES; r++) begin : g_lane
        localparam bit IS_EVEN = (r % 2) == 0;
        assign col_out[COL_W-1-BYTE_W*r -: BYTE_W] =
            col_in[COL_W-1-BYTE_W*r -: BYTE_W] ^ (IS_EVEN ? even_term : odd_term);
    end
endmodule

// File: rtl/mixcol_fwd.sv
// Forward column mix: out[r] = a[r] ^ sum ^ dbl(a[r] ^ a[r+1]).
module mixcol_fwd
    import mixcol_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    logic [BYTE_W-1:0] col_sum;

    assign col_sum = col_byte(col_in, 0) ^ col_byte(col_in, 1)
                   ^ col_byte(col_in, 2) ^ col_byte(col_in, 3);

    for (genvar r = 0; r < COL_BYTES; r++) begin : g_lane
        localparam int NXT = (r + 1) % COL_BYTES;
        logic [BYTE_W-1:0] here_b;
        logic [BYTE_W-1:0] next_b;
        assign here_b = col_in[COL_W-1-BYTE_W*r   -: BYTE_W];
        assign next_b = col_in[COL_W-1-BYTE_W*NXT -: BYTE_W];
        assign col_out[COL_W-1-BYTE_W*r -: BYTE_W] = here_b ^ col_sum ^ gf_dbl(here_b ^ next_b);
    end
endmodule

// File: rtl/mixcol_column.sv
module mixcol_column
    import mixcol_pkg::*;
(
    input  logic             dec,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] corrected;

    mixcol_precorr u_precorr (
        .dec     (dec),
        .col_in  (col_in),
        .col_out (corrected)
    );

    mixcol_fwd u_fwd (
        .col_in  (corrected),
        .col_out (col_out)
    );
endmodule

// File: rtl/mixcol_state.sv
module mixcol_state
    import mixcol_pkg::*;
#(
    parameter int NCOL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec,
    input  logic [NCOL*COL_W-1:0]   state_in,
    output logic [NCOL*COL_W-1:0]   state_out
);
    localparam int STATE_W = NCOL * COL_W;

    typedef struct packed {
        logic [STATE_W-1:0] mixed;
    } regs_t;

    regs_t              regs_d;
    regs_t              regs_q;
    logic [STATE_W-1:0] mixed_comb;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int HI = STATE_W - 1 - COL_W * c;

        mixcol_column u_column (
            .dec     (dec),
            .col_in  (state_in[HI -: COL_W]),
            .col_out (mixed_comb[HI -: COL_W])
        );

        AST_COL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |->
            ((state_out[HI -: 8] ^ state_out[HI-8 -: 8] ^ state_out[HI-16 -: 8] ^ state_out[HI-24 -: 8])
             == $past(state_in[HI -: 8] ^ state_in[HI-8 -: 8] ^ state_in[HI-16 -: 8] ^ state_in[HI-24 -: 8])))
            else $error("column parity broken"); // R7
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.mixed = mixed_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_out = regs_q.mixed;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> state_out == '0)
        else $error("output not cleared in reset"); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_in == $past(state_in) && dec == $past(dec)) |=> $stable(state_out))
        else $error("output moved with steady inputs"); // R2

    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_in == '0) |=> (state_out == '0))
        else $error("zero state not preserved"); // R8
endmodule

// File: tb/mixcol_state_tb.sv
module mixcol_state_tb;
    localparam int CLK_P = 10;
    localparam int NCOL  = 4;
    localparam int SW    = NCOL * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec = 1'b0;
    logic [SW-1:0] state_in = '0;
    logic [SW-1:0] state_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    mixcol_state #(.NCOL(NCOL)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .state_in  (state_in),
        .state_out (state_out)
    );

    // General GF(2^8) product by shift-and-add.
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [31:0] ref_col(input logic [31:0] c, input logic d);
        logic [7:0] k [4];
        logic [7:0] a [4];
        logic [31:0] r = '0;
        if (d) begin k[0] = 8'h0E; k[1] = 8'h0B; k[2] = 8'h0D; k[3] = 8'h09; end
        else   begin k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01; end
        for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
        for (int row = 0; row < 4; row++) begin
            logic [7:0] acc = 8'h00;
            for (int j = 0; j < 4; j++) acc ^= gmul(k[(j - row + 4) % 4], a[j]);
            r[31-8*row -: 8] = acc;
        end
        return r;
    endfunction

    function automatic logic [SW-1:0] ref_state(input logic [SW-1:0] s, input logic d);
        logic [SW-1:0] r;
        for (int c = 0; c < NCOL; c++) r[SW-1-32*c -: 32] = ref_col(s[SW-1-32*c -: 32], d);
        return r;
    endfunction

    function automatic logic [7:0] col_par(input logic [31:0] c);
        return c[31:24] ^ c[23:16] ^ c[15:8] ^ c[7:0];
    endfunction

    task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is visible at the next falling edge.
    task automatic apply(input logic [SW-1:0] s, input logic d);
        state_in = s;
        dec = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] prev_exp;
        logic [SW-1:0] s;
        logic [SW-1:0] enc_out;
        void'($urandom(32'h5EED_1234));
        state_in = {32'hdb135345, 32'hf20a225c, 32'hd4bf5d30, 32'h01010101};
        repeat (3) @(negedge clk);
        chk("R1 reset clears", state_out, '0);
        rst_n = 1'b1;

        // R3 known forward vectors, incl. R9 reduction column f20a225c
        apply({32'hdb135345, 32'hf20a225c, 32'hd4bf5d30, 32'hc6c6c6c6}, 1'b0);
        chk("R3 forward vectors", state_out, {32'h8e4da1bc, 32'h9fdc589d, 32'h046681e5, 32'hc6c6c6c6});
        chk("R9 reduction column", {96'h0, state_out[95:64]}, {96'h0, 32'h9fdc589d});

        // R2: output holds until the next rising edge
        state_in = {32'h8e4da1bc, 32'h9fdc589d, 32'h046681e5, 32'hc6c6c6c6};
        dec = 1'b1;
        #(CLK_P/4);
        chk("R2 hold before edge", state_out, {32'h8e4da1bc, 32'h9fdc589d, 32'h046681e5, 32'hc6c6c6c6});
        @(negedge clk);
        chk("R4 inverse vectors", state_out, {32'hdb135345, 32'hf20a225c, 32'hd4bf5d30, 32'hc6c6c6c6});

        // R8 zero in both directions
        apply('0, 1'b0);
        chk("R8 zero enc", state_out, '0);
        apply('0, 1'b1);
        chk("R8 zero dec", state_out, '0);

        // R6: alter only column 2
        s = {$urandom, $urandom, $urandom, $urandom};
        apply(s, 1'b0);
        prev_exp = state_out;
        s[63:32] = s[63:32] ^ 32'h00ff0010;
        apply(s, 1'b0);
        chk("R6 other columns unchanged", {state_out[127:64], state_out[31:0]},
            {prev_exp[127:64], prev_exp[31:0]});
        chk("R6 changed column", state_out, ref_state(s, 1'b0));

        // R5/R2: back-to-back data with random direction every cycle; R7 parity
        state_in = {$urandom, $urandom, $urandom, $urandom};
        dec = 1'($urandom);
        prev_exp = ref_state(state_in, dec);
        s = state_in;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            chk("R5 per-cycle direction", state_out, prev_exp);
            for (int c = 0; c < NCOL; c++) begin
                checks++;
                if (col_par(state_out[SW-1-32*c -: 32]) !== col_par(s[SW-1-32*c -: 32])) begin
                    errors++;
                    $display("FAIL R7 parity actual=%h expected=%h",
                             col_par(state_out[SW-1-32*c -: 32]), col_par(s[SW-1-32*c -: 32]));
                end
            end
            s = {$urandom, $urandom, $urandom, $urandom};
            if (n % 7 == 0) s[31:0] = 32'h80808080;
            state_in = s;
            dec = 1'($urandom);
            prev_exp = ref_state(s, dec);
        end
        @(negedge clk);
        chk("R5 last in stream", state_out, prev_exp);

        // R4 round trip
        for (int n = 0; n < 100; n++) begin
            s = {$urandom, $urandom, $urandom, $urandom};
            apply(s, 1'b0);
            chk("R3 random forward", state_out, ref_state(s, 1'b0));
            enc_out = state_out;
            apply(enc_out, 1'b1);
            chk("R4 round trip", state_out, s);
        end

        // R1 reset mid-run
        apply({4{32'hdeadbeef}}, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", state_out, '0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule